// File: doc/BRIEF.md
# Scanline playfield serializer

This block turns three small software-written pattern registers into a one-bit playfield pixel stream for the visible part of every scanline. The three registers are a 4-bit lead field, an 8-bit middle field and an 8-bit tail field. Together they make 20 coarse pixels. Each coarse pixel is four colour clocks wide, so the 20 pixels fill one half of the visible line.

The left half of the line reads the registers first. When the beam crosses the centre, the right half reads the same registers again. Nothing is latched per line. A write that lands after a field has finished drawing on the left half, and before that field starts on the right half, changes only the right half. Software can use this to give the two halves different patterns. Those safe write windows follow directly from the pixel timing.

The horizontal position comes from an external line timer. The register write port is a simple enable, select and data triple. Colour, priority and mirroring are handled elsewhere.

Top module: `playfield_serializer`

## Requirements
- R1: Reset clears all three pattern registers. After reset, with no writes, `pf_on` is 0 at every horizontal position of a line.
- R2: The visible window covers horizontal positions 68 through 227. The left half is 68–147 and the right half is 148–227. Each of the 20 coarse pixels of a half lasts 4 positions.
- R3: Within a half, coarse pixels 0–3 are lead bits 0,1,2,3. Coarse pixels 4–11 are middle bits 7 down to 0. Coarse pixels 12–19 are tail bits 0 up to 7.
- R4: `pf_on` is 0 for horizontal positions 0 through 67, whatever the register contents.
- R5: The right half reads the same registers as the left half. With no writes during a line, the pixel at position h equals the pixel at position h+80 for h in 68..147.
- R6: A write presented while `hpos` equals h is stored at the following clock edge. It is visible from position h+1 on, and never at h. `wr_sel` codes are: 0 selects lead, 1 selects middle, 2 selects tail.
- R7: Some writes change only the right half. A lead write at positions 84–147 does this, as does a middle write at 116–163 and a tail write at 148–195. In each case the left half of that line keeps the old pattern.
- R8: `wr_sel` code 3 is ignored and leaves all registers unchanged. A lead write keeps only `wr_data[3:0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Colour clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hpos | input | 8 | Horizontal position from the line timer, 0..227 |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 lead, 1 middle, 2 tail, 3 none |
| wr_data | input | 8 | Write data |
| pf_on | output | 1 | Playfield pixel for the current position |

## Verification
The bench builds the block with its default parameters: a 68-clock blank, 4 clocks per coarse pixel, and fields of 4, 8 and 8 bits, giving a 228-position line. At these values every safe window and every unsafe in-segment write can be reached within one line. So the bench places writes both inside each field's window and in the middle of a segment being drawn. It then compares all 228 positions against a per-pixel model.

// File: rtl/pfs_pkg.sv
package pfs_pkg;
   typedef enum logic [1:0] {
      SEL_LEAD = 2'd0,
      SEL_MID  = 2'd1,
      SEL_TAIL = 2'd2,
      SEL_NONE = 2'd3
   } sel_e;
endpackage

// File: rtl/pfs_regs.sv
module pfs_regs #(
   parameter int LW = 4,
   parameter int MW = 8,
   parameter int TW = 8,
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [1:0]    wr_sel,
   input  logic [DW-1:0] wr_data,
   output logic [LW-1:0] lead_q,
   output logic [MW-1:0] mid_q,
   output logic [TW-1:0] tail_q
);
   // Live pattern storage: read twice per line, never snapshotted.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lead_q <= '0;
         mid_q  <= '0;
         tail_q <= '0;
      end else if (wr_en) begin
         case (pfs_pkg::sel_e'(wr_sel))
            pfs_pkg::SEL_LEAD: lead_q <= wr_data[LW-1:0];
            pfs_pkg::SEL_MID:  mid_q  <= wr_data[MW-1:0];
            pfs_pkg::SEL_TAIL: tail_q <= wr_data[TW-1:0];
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/pfs_locate.sv
module pfs_locate #(
   parameter int HW    = 8,
   parameter int BLANK = 68,
   parameter int LINE  = 228,
   parameter int CPB   = 4,
   parameter int BITS  = 20,
   parameter int IW    = 5
) (
   input  logic [HW-1:0] hpos,
   output logic          visible,
   output logic [IW-1:0] idx
);
   localparam int HALF = BITS * CPB;
   localparam int SH   = $clog2(CPB);

   logic [HW-1:0] rel;
   logic [HW-1:0] off;

   always_comb begin
      visible = (hpos >= HW'(BLANK)) && (hpos < HW'(LINE));
      rel     = hpos - HW'(BLANK);
      // Second half folds back onto the same coarse-pixel index.
      off     = (rel >= HW'(HALF)) ? rel - HW'(HALF) : rel;
   end

   generate
      if ((1 << SH) == CPB) begin : g_shift
         assign idx = IW'(off >> SH);
      end else begin : g_div
         assign idx = IW'(off / HW'(CPB));
      end
   endgenerate
endmodule

// File: rtl/pfs_pick.sv
module pfs_pick #(
   parameter int LW        = 4,
   parameter int MW        = 8,
   parameter int TW        = 8,
   parameter int IW        = 5,
   parameter bit MID_MSB1  = 1'b1,
   parameter bit TAIL_MSB1 = 1'b0
) (
   input  logic [LW-1:0] lead,
   input  logic [MW-1:0] mid,
   input  logic [TW-1:0] tail,
   input  logic [IW-1:0] idx,
   input  logic          visible,
   output logic          pix
);
   localparam int BITS = LW + MW + TW;

   logic [BITS-1:0] seq;   // seq[i] is coarse pixel i of a half

   generate
      for (genvar i = 0; i < LW; i++) begin : g_lead
         assign seq[i] = lead[i];
      end
      for (genvar j = 0; j < MW; j++) begin : g_mid
         if (MID_MSB1) begin : g_rev
            assign seq[LW+j] = mid[MW-1-j];
         end else begin : g_fwd
            assign seq[LW+j] = mid[j];
         end
      end
      for (genvar k = 0; k < TW; k++) begin : g_tail
         if (TAIL_MSB1) begin : g_rev
            assign seq[LW+MW+k] = tail[TW-1-k];
         end else begin : g_fwd
            assign seq[LW+MW+k] = tail[k];
         end
      end
   endgenerate

   assign pix = visible && ({1'b0, idx} < (IW+1)'(BITS)) && seq[idx];
endmodule

// File: rtl/playfield_serializer.sv
module playfield_serializer #(
   parameter int LEAD_W         = 4,
   parameter int MID_W          = 8,
   parameter int TAIL_W         = 8,
   parameter int DATA_W         = 8,
   parameter int BLANK_CLKS     = 68,
   parameter int CLKS_PER_BIT   = 4,
   parameter int LINE_CLKS      = 228,
   parameter bit MID_MSB_FIRST  = 1'b1,
   parameter bit TAIL_MSB_FIRST = 1'b0,
   localparam int HPOS_W        = $clog2(LINE_CLKS + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [HPOS_W-1:0] hpos,
   input  logic              wr_en,
   input  logic [1:0]        wr_sel,
   input  logic [DATA_W-1:0] wr_data,
   output logic              pf_on
);
   localparam int BITS = LEAD_W + MID_W + TAIL_W;
   localparam int IW   = $clog2(BITS);

   generate
      if (BLANK_CLKS + 2 * BITS * CLKS_PER_BIT != LINE_CLKS) begin : g_bad_line
         $error("line length does not equal blank plus two halves");
      end
      if (LEAD_W > DATA_W || MID_W > DATA_W || TAIL_W > DATA_W) begin : g_bad_width
         $error("a pattern field is wider than the write data");
      end
      if (CLKS_PER_BIT < 1) begin : g_bad_cpb
         $error("clocks per coarse pixel must be at least one");
      end
   endgenerate

   logic [LEAD_W-1:0] lead_q;
   logic [MID_W-1:0]  mid_q;
   logic [TAIL_W-1:0] tail_q;
   logic              visible;
   logic [IW-1:0]     idx;

   pfs_regs #(.LW(LEAD_W), .MW(MID_W), .TW(TAIL_W), .DW(DATA_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
      .wr_data(wr_data), .lead_q(lead_q), .mid_q(mid_q), .tail_q(tail_q)
   );

   pfs_locate #(.HW(HPOS_W), .BLANK(BLANK_CLKS), .LINE(LINE_CLKS),
                .CPB(CLKS_PER_BIT), .BITS(BITS), .IW(IW)) u_loc (
      .hpos(hpos), .visible(visible), .idx(idx)
   );

   pfs_pick #(.LW(LEAD_W), .MW(MID_W), .TW(TAIL_W), .IW(IW),
              .MID_MSB1(MID_MSB_FIRST), .TAIL_MSB1(TAIL_MSB_FIRST)) u_pick (
      .lead(lead_q), .mid(mid_q), .tail(tail_q), .idx(idx),
      .visible(visible), .pix(pf_on)
   );
endmodule

// File: rtl/playfield_serializer_chk.sv
module playfield_serializer_chk #(
   parameter int LEAD_W     = 4,
   parameter int MID_W      = 8,
   parameter int TAIL_W     = 8,
   parameter int DATA_W     = 8,
   parameter int BLANK_CLKS = 68,
   parameter int LINE_CLKS  = 228,
   parameter int HPOS_W     = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic [HPOS_W-1:0] hpos,
   input logic              wr_en,
   input logic [1:0]        wr_sel,
   input logic [DATA_W-1:0] wr_data,
   input logic [LEAD_W-1:0] lead_q,
   input logic [MID_W-1:0]  mid_q,
   input logic [TAIL_W-1:0] tail_q,
   input logic              pf_on
);
   a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (lead_q == '0 && mid_q == '0 && tail_q == '0));

   a_r4_blank_dark: assert property (@(posedge clk) disable iff (!rst_n)
      (hpos < HPOS_W'(BLANK_CLKS)) |-> !pf_on);

   a_r2_past_line_dark: assert property (@(posedge clk) disable iff (!rst_n)
      (hpos >= HPOS_W'(LINE_CLKS)) |-> !pf_on);

   a_r6_lead_lands: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel == 2'd0) |=> (lead_q == $past(wr_data[LEAD_W-1:0])));

   a_r6_mid_lands: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel == 2'd1) |=> (mid_q == $past(wr_data[MID_W-1:0])));

   a_r6_tail_lands: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel == 2'd2) |=> (tail_q == $past(wr_data[TAIL_W-1:0])));

   a_r8_reserved_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel == 2'd3) |=> ($stable(lead_q) && $stable(mid_q) && $stable(tail_q)));

   a_r6_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> ($stable(lead_q) && $stable(mid_q) && $stable(tail_q)));
endmodule

bind playfield_serializer playfield_serializer_chk #(
   .LEAD_W(LEAD_W), .MID_W(MID_W), .TAIL_W(TAIL_W), .DATA_W(DATA_W),
   .BLANK_CLKS(BLANK_CLKS), .LINE_CLKS(LINE_CLKS), .HPOS_W(HPOS_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .hpos(hpos), .wr_en(wr_en), .wr_sel(wr_sel),
   .wr_data(wr_data), .lead_q(lead_q), .mid_q(mid_q), .tail_q(tail_q),
   .pf_on(pf_on)
);

// File: tb/sim_playfield_serializer.sv
module sim_playfield_serializer;
   logic       clk = 1'b0;
   logic       rst_n;
   logic [7:0] hpos;
   logic       wr_en;
   logic [1:0] wr_sel;
   logic [7:0] wr_data;
   logic       pf_on;

   int n_chk = 0;
   int n_fail = 0;
   logic [3:0] m_lead;
   logic [7:0] m_mid, m_tail;

   always #5 clk = ~clk;

   playfield_serializer u0 (
      .clk(clk), .rst_n(rst_n), .hpos(hpos), .wr_en(wr_en),
      .wr_sel(wr_sel), .wr_data(wr_data), .pf_on(pf_on)
   );

   // Expected pixel from R2/R3/R4/R5.
   function automatic logic ref_pix(int h, logic [3:0] a, logic [7:0] b, logic [7:0] c);
      int r, p;
      if (h < 68 || h > 227) return 1'b0;
      r = h - 68;
      if (r >= 80) r = r - 80;
      p = r / 4;
      if (p < 4)  return a[p];
      if (p < 12) return b[11 - p];
      return c[p - 12];
   endfunction

   task automatic check(string req, bit ok, string what, int act, int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic model_write(logic [1:0] s, logic [7:0] d);
      case (s)
         2'd0: m_lead = d[3:0];
         2'd1: m_mid  = d;
         2'd2: m_tail = d;
         default: ;
      endcase
   endtask

   task automatic write_reg(logic [1:0] s, logic [7:0] d);
      @(negedge clk);
      hpos = 8'd0; wr_en = 1'b1; wr_sel = s; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
      model_write(s, d);
   endtask

   task automatic set_all(logic [3:0] a, logic [7:0] b, logic [7:0] c);
      write_reg(2'd0, {4'h0, a});
      write_reg(2'd1, b);
      write_reg(2'd2, c);
   endtask

   task automatic probe(int h, output logic v);
      @(negedge clk);
      hpos = 8'(h); wr_en = 1'b0;
      #1 v = pf_on;
   endtask

   // One full line with an optional write at position wpos; every position compared.
   task automatic run_line(string req, bit do_wr, int wpos, logic [1:0] s, logic [7:0] d);
      int bad = 0;
      int first = -1;
      logic gf = 1'b0, ef = 1'b0;
      for (int h = 0; h < 228; h++) begin
         logic e;
         @(negedge clk);
         hpos = 8'(h);
         wr_en = do_wr && (h == wpos);
         wr_sel = s; wr_data = d;
         #1;
         e = ref_pix(h, m_lead, m_mid, m_tail);
         if (pf_on !== e) begin
            if (first < 0) begin first = h; gf = pf_on; ef = e; end
            bad++;
         end
         if (do_wr && h == wpos) model_write(s, d);
      end
      @(negedge clk);
      wr_en = 1'b0;
      if (bad == 0) check(req, 1'b1, "line", 0, 0);
      else check(req, 1'b0, $sformatf("line pixel at hpos %0d (%0d bad)", first, bad), int'(gf), int'(ef));
   endtask

   task automatic t_reset;
      logic v;
      run_line("R1", 1'b0, 0, 2'd0, 8'h00);
      probe(100, v);
      check("R1", v == 1'b0, "pixel after reset", int'(v), 0);
   endtask

   task automatic t_order;
      logic v;
      set_all(4'b0001, 8'h00, 8'h00);
      probe(71, v);  check("R3", v == 1'b1, "lead bit0 last clock", int'(v), 1);
      probe(72, v);  check("R3", v == 1'b0, "lead bit1", int'(v), 0);
      probe(148, v); check("R5", v == 1'b1, "right half lead bit0", int'(v), 1);
      set_all(4'h0, 8'h80, 8'h01);
      probe(84, v);  check("R3", v == 1'b1, "middle msb first", int'(v), 1);
      probe(88, v);  check("R3", v == 1'b0, "middle bit6", int'(v), 0);
      probe(116, v); check("R3", v == 1'b1, "tail lsb first", int'(v), 1);
      set_all(4'hA, 8'h81, 8'h6D);
      run_line("R3", 1'b0, 0, 2'd0, 8'h00);
      set_all(4'h5, 8'h3C, 8'hF0);
      run_line("R5", 1'b0, 0, 2'd0, 8'h00);
   endtask

   task automatic t_blank;
      logic v;
      set_all(4'hF, 8'hFF, 8'hFF);
      probe(0, v);   check("R4", v == 1'b0, "blank start", int'(v), 0);
      probe(67, v);  check("R4", v == 1'b0, "blank end", int'(v), 0);
      probe(68, v);  check("R2", v == 1'b1, "first visible", int'(v), 1);
      probe(227, v); check("R2", v == 1'b1, "last visible", int'(v), 1);
   endtask

   task automatic t_safe;
      logic v;
      set_all(4'h3, 8'hC3, 8'h5A);
      run_line("R7", 1'b1, 100, 2'd0, 8'h0C);
      run_line("R5", 1'b0, 0, 2'd0, 8'h00);
      run_line("R7", 1'b1, 130, 2'd1, 8'h18);
      run_line("R7", 1'b1, 190, 2'd2, 8'hA5);
      set_all(4'h0, 8'h00, 8'h00);
      run_line("R7", 1'b1, 147, 2'd0, 8'h0F);
      probe(68, v);  check("R7", v == 1'b1, "lead stays new next line", int'(v), 1);
   endtask

   task automatic t_unsafe;
      logic v;
      set_all(4'h0, 8'hFF, 8'h00);
      run_line("R6", 1'b1, 95, 2'd1, 8'h00);
      set_all(4'h0, 8'h00, 8'h00);
      @(negedge clk);
      hpos = 8'd84; wr_en = 1'b1; wr_sel = 2'd1; wr_data = 8'hFF;
      #1 v = pf_on;
      check("R6", v == 1'b0, "write not visible same position", int'(v), 0);
      @(negedge clk);
      hpos = 8'd85; wr_en = 1'b0;
      #1 v = pf_on;
      check("R6", v == 1'b1, "write visible next position", int'(v), 1);
      model_write(2'd1, 8'hFF);
      run_line("R6", 1'b1, 70, 2'd0, 8'h0F);
   endtask

   task automatic t_reserved;
      set_all(4'h9, 8'h42, 8'h24);
      run_line("R8", 1'b1, 60, 2'd3, 8'hFF);
      run_line("R8", 1'b1, 10, 2'd0, 8'hF0);
   endtask

   task automatic t_reset_again;
      set_all(4'hF, 8'hFF, 8'hFF);
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); @(negedge clk); rst_n = 1'b1;
      m_lead = '0; m_mid = '0; m_tail = '0;
      run_line("R1", 1'b0, 0, 2'd0, 8'h00);
   endtask

   initial begin
      #(10 * 200000);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      rst_n = 1'b0; hpos = 8'd0; wr_en = 1'b0; wr_sel = 2'd0; wr_data = 8'd0;
      m_lead = '0; m_mid = '0; m_tail = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_order();
      t_blank();
      t_safe();
      t_unsafe();
      t_reserved();
      t_reset_again();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule